// File: doc/BRIEF.md
# Two-Bank Level-Sensitive Interrupt Aggregator

This block collects level-sensitive interrupt requests from peripherals and presents two active-low request lines to a CPU. One is a normal request line fed by up to 32 source pins plus a software-written request word. The other is a fast request line fed by a single dedicated source pin. Each line has its own enable mask. A bit set in the mask lets the matching pending source pull the line low.

Software reaches two register banks over a simple synchronous 32-bit bus. `bus_bank` picks the bank: 0 selects the normal bank and 1 selects the fast bank. `bus_addr` gives a byte offset inside the bank. Enable masks are never written directly. Software changes them through a write-one-to-set word and a write-one-to-clear word. The set word shares its offset with the read view of the mask. The request outputs are computed combinationally from the source pins and the stored registers. A change to a source pin or a mask therefore shows on the outputs at once, without waiting for another edge of the source.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While `rst_n` is low, the normal mask, the fast mask and the software word are all zero, and both `irq_n` and `fiq_n` are 1.
- R2: `irq_n` is 0 exactly when ((`irq_src` OR software word) AND normal mask) is nonzero. A source change is seen in the same cycle, with no clock edge needed.
- R3: `fiq_n` is 0 exactly when `fiq_src` is 1 and bit 0 of the fast mask is 1.
- R4: In the normal bank (bank 0), a write to offset 0x08 ORs the write data into the normal mask. A read of offset 0x08 returns the mask.
- R5: In the normal bank, a write to offset 0x0C clears each mask bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: In the fast bank (bank 1), offset 0x08 sets fast-mask bits on a write and returns the fast mask on a read. Offset 0x0C clears fast-mask bits on a write.
- R7: In the normal bank, a write to offset 0x10 replaces the software word. The software word acts as extra source bits in the raw status, and writing 0 withdraws all software requests.
- R8: A read of offset 0x04 returns raw status. In the normal bank this is `irq_src` OR the software word. In the fast bank it is `fiq_src` in bit 0, with 0 in all other bits.
- R9: A read of offset 0x00 returns the raw status of that bank ANDed with the bank's mask.
- R10: The following reads return 0: any offset not listed above, any unaligned offset, any offset at or above 0x20, and the write-only offsets 0x0C and 0x10. `bus_rdata` is also 0 when no read is in progress. A write to any offset other than the set, clear and software words changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_SRC | Level-sensitive normal interrupt sources, active-high |
| fiq_src | input | 1 | Level-sensitive fast interrupt source, active-high |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | Bank select: 0 normal, 1 fast |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_n | output | 1 | Normal interrupt request, active-low |
| fiq_n | output | 1 | Fast interrupt request, active-low |

## Verification
The assertions check the following on every clock cycle:
- the set, clear and replace update rules for the mask and software registers;
- that the masks hold their value through any other bus access;
- that both request lines are idle during reset;
- the bounds relating each request line to its sources.

Some behaviour can only be shown by the bench's scenarios. One is that a request falls or rises in the same cycle as a source change, with no clock edge involved. Another is that status reads, and the outputs after sequences of mixed set and clear writes, match the model. These scenarios include an unaligned offset, an out-of-range offset and write-only offsets.

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl #(
  parameter int N_SRC = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             fiq_src,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic             bus_bank,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_n,
  output logic             fiq_n
);
  localparam int DW = 32;
  localparam logic [2:0] W_MSK = 3'd0;
  localparam logic [2:0] W_RAW = 3'd1;
  localparam logic [2:0] W_SET = 3'd2;
  localparam logic [2:0] W_CLR = 3'd3;
  localparam logic [2:0] W_SW  = 3'd4;

  logic [DW-1:0] irq_en, fiq_en, sw_req;
  logic [DW-1:0] irq_raw, fiq_raw, irq_msk, fiq_msk;
  logic [2:0]    word;
  logic          mapped, wr_n, wr_f, rd_n, rd_f;

  assign irq_raw = DW'(irq_src) | sw_req;
  assign fiq_raw = {{(DW-1){1'b0}}, fiq_src};
  assign irq_msk = irq_raw & irq_en;
  assign fiq_msk = fiq_raw & fiq_en;

  assign irq_n = ~|irq_msk;
  assign fiq_n = ~fiq_msk[0];

  assign word   = bus_addr[4:2];
  assign mapped = ((bus_addr >> 5) == '0) && (bus_addr[1:0] == 2'b00);
  assign wr_n   = bus_en &  bus_wr & ~bus_bank & mapped;
  assign wr_f   = bus_en &  bus_wr &  bus_bank & mapped;
  assign rd_n   = bus_en & ~bus_wr & ~bus_bank & mapped;
  assign rd_f   = bus_en & ~bus_wr &  bus_bank & mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      fiq_en <= '0;
      sw_req <= '0;
    end else begin
      if (wr_n && word == W_SET) irq_en <= irq_en | bus_wdata;
      if (wr_n && word == W_CLR) irq_en <= irq_en & ~bus_wdata;
      if (wr_n && word == W_SW)  sw_req <= bus_wdata;
      if (wr_f && word == W_SET) fiq_en <= fiq_en | bus_wdata;
      if (wr_f && word == W_CLR) fiq_en <= fiq_en & ~bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_n) begin
      case (word)
        W_MSK:   bus_rdata = irq_msk;
        W_RAW:   bus_rdata = irq_raw;
        W_SET:   bus_rdata = irq_en;
        default: bus_rdata = '0;
      endcase
    end else if (rd_f) begin
      case (word)
        W_MSK:   bus_rdata = fiq_msk;
        W_RAW:   bus_rdata = fiq_raw;
        W_SET:   bus_rdata = fiq_en;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module irq_fiq_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_src,
  input logic             fiq_src,
  input logic             bus_en,
  input logic             bus_wr,
  input logic             bus_bank,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq_n,
  input logic             fiq_n,
  input logic [31:0]      irq_en,
  input logic [31:0]      fiq_en,
  input logic [31:0]      sw_req
);
  logic wr0, wr1, rd0;
  assign wr0 = bus_en && bus_wr && !bus_bank;
  assign wr1 = bus_en && bus_wr && bus_bank;
  assign rd0 = bus_en && !bus_wr && !bus_bank;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (irq_n && fiq_n));

  p_quiet_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0 && sw_req == '0) |-> irq_n);

  p_fiq_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_n |-> (fiq_src && fiq_en[0]));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_addr == AW'(8'h08)) |=> irq_en == ($past(irq_en) | $past(bus_wdata)));

  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_addr == AW'(8'h0C)) |=> irq_en == ($past(irq_en) & ~$past(bus_wdata)));

  p_fset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && bus_addr == AW'(8'h08)) |=> fiq_en == ($past(fiq_en) | $past(bus_wdata)));

  p_fclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && bus_addr == AW'(8'h0C)) |=> fiq_en == ($past(fiq_en) & ~$past(bus_wdata)));

  p_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_addr == AW'(8'h10)) |=> sw_req == $past(bus_wdata));

  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr0 && (bus_addr == AW'(8'h08) || bus_addr == AW'(8'h0C))) |=> $stable(irq_en));

  p_wo_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && (bus_addr == AW'(8'h0C) || bus_addr == AW'(8'h10))) |-> bus_rdata == '0);

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_rdata == '0);
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .fiq_src(fiq_src),
  .bus_en(bus_en), .bus_wr(bus_wr), .bus_bank(bus_bank), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n), .fiq_n(fiq_n),
  .irq_en(irq_en), .fiq_en(fiq_en), .sw_req(sw_req)
);

// File: tb/irq_fiq_ctrl_bench.sv
module irq_fiq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 32;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic [N_SRC-1:0] irq_src = '0;
  logic fiq_src = 0;
  logic bus_en = 0, bus_wr = 0, bus_bank = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_n, fiq_n;

  int tests = 0, fails = 0;
  logic [31:0] m_en = '0, m_fen = '0, m_sw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_fiq_ctrl #(.N_SRC(N_SRC), .AW(AW)) u_irq_fiq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .fiq_src(fiq_src),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n), .fiq_n(fiq_n));

  function automatic logic [31:0] raw_n(); return 32'(irq_src) | m_sw; endfunction
  function automatic logic [31:0] raw_f(); return {31'b0, fiq_src}; endfunction

  function automatic logic [31:0] exp_read(logic bank, logic [AW-1:0] a);
    if (a[1:0] != 2'b00 || a >= AW'(8'h20)) return '0;
    if (!bank) case (a[4:2])
      3'd0: return raw_n() & m_en;
      3'd1: return raw_n();
      3'd2: return m_en;
      default: return '0;
    endcase
    case (a[4:2])
      3'd0: return raw_f() & m_fen;
      3'd1: return raw_f();
      3'd2: return m_fen;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    check("R2 irq_n", {31'b0, irq_n}, {31'b0, ~|(raw_n() & m_en)});
    check("R3 fiq_n", {31'b0, fiq_n}, {31'b0, ~(fiq_src & m_fen[0])});
  endtask

  task automatic bus_write(logic bank, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_bank = bank; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
    if (a[1:0] == 2'b00 && a < AW'(8'h20)) begin
      if (!bank && a[4:2] == 3'd2) m_en = m_en | d;
      if (!bank && a[4:2] == 3'd3) m_en = m_en & ~d;
      if (!bank && a[4:2] == 3'd4) m_sw = d;
      if ( bank && a[4:2] == 3'd2) m_fen = m_fen | d;
      if ( bank && a[4:2] == 3'd3) m_fen = m_fen & ~d;
    end
    #1;
  endtask

  task automatic bus_read(string req, logic bank, logic [AW-1:0] a);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_bank = bank; bus_addr = a;
    #1;
    check(req, bus_rdata, exp_read(bank, a));
    bus_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [8];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h02, 8'h40};
    void'($urandom(32'd2024));
    irq_src = '1; fiq_src = 1;
    #(CLK_PERIOD * 3);
    // R1: reset state with sources active
    check("R1 irq_n in reset", {31'b0, irq_n}, 32'd1);
    check("R1 fiq_n in reset", {31'b0, fiq_n}, 32'd1);
    @(negedge clk); rst_n = 1;
    bus_read("R1 enable after reset", 0, 8'h08);
    bus_read("R1 fast enable after reset", 1, 8'h08);
    irq_src = '0; fiq_src = 0;
    // R4 / R5 directed
    bus_write(0, 8'h08, 32'h0000_00F0);
    bus_write(0, 8'h08, 32'h8000_0001);
    bus_read("R4 set accumulates", 0, 8'h08);
    bus_write(0, 8'h0C, 32'h0000_0030);
    bus_read("R5 clear selected bits", 0, 8'h08);
    // R2 combinational response to source
    @(negedge clk); irq_src = 32'h0000_0040; #1;
    check("R2 source same cycle", {31'b0, irq_n}, 32'd0);
    irq_src = 32'h0000_0020; #1;
    check("R2 masked source", {31'b0, irq_n}, 32'd1);
    // R7 software word
    bus_write(0, 8'h10, 32'h8000_0000);
    check("R7 software raise", {31'b0, irq_n}, 32'd0);
    bus_read("R8 raw includes sw", 0, 8'h04);
    bus_read("R9 masked status", 0, 8'h00);
    bus_write(0, 8'h10, 32'h0);
    check("R7 software withdraw", {31'b0, irq_n}, 32'd1);
    // R6 / R3 fast bank
    fiq_src = 1; #1;
    check("R3 fast masked", {31'b0, fiq_n}, 32'd1);
    bus_write(1, 8'h08, 32'h0000_0001);
    check("R3 fast enabled", {31'b0, fiq_n}, 32'd0);
    bus_read("R8 fast raw", 1, 8'h04);
    bus_read("R9 fast masked", 1, 8'h00);
    bus_write(1, 8'h0C, 32'h0000_0001);
    check("R6 fast clear", {31'b0, fiq_n}, 32'd1);
    // R10 ignored writes and reserved reads
    bus_write(0, 8'h00, 32'hFFFF_FFFF);
    bus_write(0, 8'h04, 32'hFFFF_FFFF);
    bus_write(0, 8'h0A, 32'hFFFF_FFFF);
    bus_write(0, 8'h48, 32'hFFFF_FFFF);
    bus_write(1, 8'h10, 32'hFFFF_FFFF);
    bus_read("R10 enable untouched", 0, 8'h08);
    bus_read("R10 fast enable untouched", 1, 8'h08);
    bus_read("R10 sw not readable", 0, 8'h10);
    bus_read("R10 clear not readable", 0, 8'h0C);
    bus_read("R10 out of range", 0, 8'h48);
    @(negedge clk); #1;
    check("R10 idle rdata", bus_rdata, 32'h0);
    check_outs();
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        @(negedge clk);
        irq_src = $urandom & $urandom; fiq_src = 1'($urandom); #1;
      end else if (op == 1) begin
        bus_write(1'($urandom), addrs[$urandom_range(0, 7)], $urandom & $urandom);
      end else begin
        bus_read("R8 R9 R4 R6 R10 random read", 1'($urandom), addrs[$urandom_range(0, 7)]);
      end
      check_outs();
    end
    // R1 again: reset mid-run clears state
    @(negedge clk); rst_n = 0; #1;
    m_en = '0; m_fen = '0; m_sw = '0;
    check("R1 reset mid-run irq_n", {31'b0, irq_n}, 32'd1);
    check("R1 reset mid-run fiq_n", {31'b0, fiq_n}, 32'd1);
    @(negedge clk); rst_n = 1;
    bus_read("R1 enable cleared", 0, 8'h08);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule